// File: doc/BRIEF.md
# Dual-Register Ranging Code Generator

This block produces a spreading code for a navigation-style ranging signal, one chip per enabled clock. Two 13-stage linear feedback shift registers run side by side. The chip is the XOR of their output stages. The first register, called XA here, always starts from the all-ones state. It is cut short before its natural period ends. The second register, called XB, starts from a value supplied by the user. That start value is the state XB reaches after some number of advances beyond all ones, and it decides which code the block emits.

Two start values are presented together, one for the in-phase code and one for the quadrature code of the same signal number. A select input chooses which of the pair is loaded. The select and the start values are sampled only at reset and at the code wrap. The code is 10230 chips long. An epoch pulse marks the last chip of each period, and on that same enabled cycle both registers are restarted.

Top module: `rc_code_gen`

## Requirements
- R1: During synchronous reset (rst_n low at a rising edge), XA is set to all ones, XB is loaded with the selected start value, and the chip counter is cleared. After reset, `chip` equals the inverse of bit 0 of that start value, and `epoch` is low.
- R2: While `chip_en` is low, neither register and not the counter change, so `chip` holds its value and `epoch` stays low.
- R3: Each register shifts toward bit 0 on every enabled clock. The new feedback bit enters at bit 12, and `chip` is the XOR of bit 0 of XA and bit 0 of XB.
- R4: For the first 13 chips after any load, chip k (k = 0..12) equals the inverse of bit k of the loaded XB start value.
- R5: XA feedback is the XOR of its bits 0, 1, 3 and 4 (tap mask 13'h001B). XA is set back to all ones on the enabled clock that ends chip 8189 of each code period, so its new run begins at chip 8190. It is also set back to all ones at each epoch.
- R6: XB feedback is the XOR of its bits 0, 1, 5, 6, 7, 9, 10 and 12 (tap mask 13'h16E3). XB runs through its full sequence without interruption and is reloaded only at an epoch.
- R7: `epoch` is high for exactly the enabled cycle that carries chip 10229, the last chip of the period. Over a run, consecutive epochs are exactly 10230 enabled chips apart.
- R8: `q_sel` = 0 picks `start_i` and `q_sel` = 1 picks `start_q`. The select and both start values take effect only at reset and at the enabled epoch cycle. Changes at any other time do not alter the chips produced before the next epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Advances the code by one chip |
| q_sel | input | 1 | 0 selects the in-phase start value, 1 selects the quadrature start value |
| start_i | input | 13 | XB start value for the in-phase code |
| start_q | input | 13 | XB start value for the quadrature code |
| chip | output | 1 | Current code chip |
| epoch | output | 1 | High on the enabled cycle of the last chip of the period |

## Verification
`chip` and `epoch` depend only on the registered state and on `chip_en` in the same cycle. The result of an enabled clock therefore appears one edge later, and a reset or reload shows up on the first cycle after the edge that applies it. The driver pushes the expected pair for each cycle while it drives `chip_en` at the falling edge. The monitor pops that pair 1 ns later in the same low phase, before the next rising edge, so every comparison sees the state and enable of exactly the cycle the model predicted. The reference model keeps its own stage array numbered 1 to 13, its own chip count and its own reload rules. It changes its start value only when it passes an epoch or a reset, which puts the mid-period select change to the test.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int RC_STAGES = 13;
  typedef logic [RC_STAGES-1:0] rc_state_t;

  // One register step: feedback from the masked bits enters at the top,
  // everything moves one place toward bit 0.
  function automatic rc_state_t rc_step(input rc_state_t s, input rc_state_t taps);
    logic fb;
    fb = ^(s & taps);
    return {fb, s[RC_STAGES-1:1]};
  endfunction

  // Chip value from the two output stages.
  function automatic logic rc_chip(input rc_state_t a, input rc_state_t b);
    return a[0] ^ b[0];
  endfunction
endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr
  import rc_pkg::*;
#(
  parameter rc_state_t TAPS = 13'h001B
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      load,
  input  rc_state_t load_val,
  output rc_state_t state
);
  rc_state_t next_state;

  always_comb begin
    next_state = state;
    if (!rst_n || load) next_state = load_val;
    else if (advance)   next_state = rc_step(state, TAPS);
  end

  always_ff @(posedge clk) state <= next_state;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(state));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == $past(load_val));
endmodule

// File: rtl/rc_epoch_counter.sv
module rc_epoch_counter #(
  parameter int CODE_LEN = 10230,
  parameter int XA_SHORT = 8190
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic code_last,
  output logic xa_last
);
  localparam int CW = $clog2(CODE_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(CODE_LEN - 1);
  localparam logic [CW-1:0] XA_IDX   = CW'(XA_SHORT - 1);

  logic [CW-1:0] cnt;

  assign code_last = (cnt == LAST_IDX);
  assign xa_last   = (cnt == XA_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (advance)    cnt <= code_last ? '0 : cnt + 1'b1;
  end

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && code_last) |=> cnt == '0);

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !code_last) |=> cnt == $past(cnt) + 1'b1);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cnt));
endmodule

// File: rtl/rc_code_gen.sv
module rc_code_gen
  import rc_pkg::*;
#(
  parameter int        CODE_LEN = 10230,
  parameter int        XA_SHORT = 8190,
  parameter rc_state_t XA_TAPS  = 13'h001B,
  parameter rc_state_t XB_TAPS  = 13'h16E3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chip_en,
  input  logic        q_sel,
  input  logic [12:0] start_i,
  input  logic [12:0] start_q,
  output logic        chip,
  output logic        epoch
);
  localparam rc_state_t ALL_ONES = '1;

  rc_state_t xa_state, xb_state, xb_pick;
  logic      code_last, xa_last;
  logic      xa_reload, xb_reload;

  assign xb_pick   = q_sel ? start_q : start_i;
  assign xa_reload = chip_en && (xa_last || code_last);
  assign xb_reload = chip_en && code_last;

  rc_epoch_counter #(.CODE_LEN(CODE_LEN), .XA_SHORT(XA_SHORT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(chip_en),
    .code_last(code_last), .xa_last(xa_last)
  );

  rc_lfsr #(.TAPS(XA_TAPS)) u_xa (
    .clk(clk), .rst_n(rst_n), .advance(chip_en), .load(xa_reload),
    .load_val(ALL_ONES), .state(xa_state)
  );

  rc_lfsr #(.TAPS(XB_TAPS)) u_xb (
    .clk(clk), .rst_n(rst_n), .advance(chip_en), .load(xb_reload),
    .load_val(xb_pick), .state(xb_state)
  );

  assign chip  = rc_chip(xa_state, xb_state);
  assign epoch = xb_reload;

  assert_xa_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xa_reload |=> xa_state == ALL_ONES);

  assert_xb_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xb_reload |=> xb_state == $past(q_sel ? start_q : start_i));

  assert_chip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(chip));

  assert_epoch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> !epoch);
endmodule

// File: tb/rc_code_gen_test.sv
module rc_code_gen_test;
  localparam int LEN   = 10230;
  localparam int SHORT = 8190;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b0;
  logic        q_sel = 1'b0;
  logic [12:0] start_i = 13'h0B5C;
  logic [12:0] start_q = 13'h1263;
  logic        chip, epoch;

  rc_code_gen uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .q_sel(q_sel),
    .start_i(start_i), .start_q(start_q), .chip(chip), .epoch(epoch)
  );

  always #2 clk = ~clk;

  // scoreboard queues
  bit    exp_chip_q[$];
  bit    exp_epoch_q[$];
  string tag_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model: stages numbered 1..13, stage 13 is the output
  bit ma [1:13];
  bit mb [1:13];
  int chips_done;
  int since_load;
  bit prev_en;
  bit first_after_rst;
  bit sel_pending;
  int epochs_seen;
  int en_gap;
  logic [15:0] pat = 16'hACE1;

  task automatic model_load_a();
    for (int n = 1; n <= 13; n++) ma[n] = 1'b1;
  endtask

  task automatic model_load_b(input logic [12:0] v);
    for (int n = 1; n <= 13; n++) mb[n] = v[13-n];
  endtask

  task automatic model_shift();
    bit fa, fb;
    fa = ma[9] ^ ma[10] ^ ma[12] ^ ma[13];
    fb = mb[1] ^ mb[3] ^ mb[4] ^ mb[6] ^ mb[7] ^ mb[8] ^ mb[12] ^ mb[13];
    for (int n = 13; n >= 2; n--) begin
      ma[n] = ma[n-1];
      mb[n] = mb[n-1];
    end
    ma[1] = fa;
    mb[1] = fb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    chip_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_load_a();
    model_load_b(q_sel ? start_q : start_i);
    chips_done      = 0;
    since_load      = 0;
    prev_en         = 1'b1;
    first_after_rst = 1'b1;
  endtask

  task automatic drive_cycle(input bit en);
    string tg;
    @(negedge clk);
    chip_en = en;
    if (first_after_rst)                                   tg = "R1";
    else if (!prev_en)                                     tg = "R2";
    else if (since_load < 13)                              tg = sel_pending ? "R8" : "R4";
    else if (chips_done >= SHORT && chips_done < SHORT+13) tg = "R5";
    else if (chips_done >= 8191 + 13)                      tg = "R6";
    else                                                   tg = "R3";
    exp_chip_q.push_back(ma[13] ^ mb[13]);
    exp_epoch_q.push_back(en && (chips_done == LEN-1));
    tag_q.push_back(tg);
    first_after_rst = 1'b0;
    prev_en = en;
    if (en) begin
      if (chips_done == LEN-1) begin
        model_load_a();
        model_load_b(q_sel ? start_q : start_i);
        chips_done = 0;
        since_load = 0;
        epochs_seen++;
      end else begin
        model_shift();
        chips_done++;
        since_load++;
        if (chips_done == SHORT) model_load_a();
      end
    end
  endtask

  // monitor: compare in the low phase, 1 ns after the driver
  always @(negedge clk) begin
    #1;
    if (exp_chip_q.size() > 0) begin
      bit ec, ee;
      string tg;
      ec = exp_chip_q.pop_front();
      ee = exp_epoch_q.pop_front();
      tg = tag_q.pop_front();
      n_checks++;
      if (chip !== ec) begin
        n_fail++;
        $display("FAIL %s chip: got %0b expected %0b (chip %0d)", tg, chip, ec, chips_done);
      end
      n_checks++;
      if (epoch !== ee) begin
        n_fail++;
        $display("FAIL R7 epoch: got %0b expected %0b", epoch, ee);
      end
    end
  end

  task automatic run_chips(input int n, input bit gaps);
    int got;
    got = 0;
    while (got < n) begin
      bit en;
      pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      en = gaps ? (pat[1:0] != 2'b00) : 1'b1;
      if (gaps && pat[7:3] == 5'd0) en_gap = 6; // occasional long idle run
      if (en_gap > 0) begin
        en = 1'b0;
        en_gap--;
      end
      drive_cycle(en);
      if (en) got++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    epochs_seen = 0;
    en_gap      = 0;
    sel_pending = 1'b0;
    // R1, R3, R4, R5, R6, R7 with in-phase start and irregular enable
    do_reset();
    run_chips(2*LEN + 40, 1'b1);
    // R8: change select and in-phase value mid-period; the new quadrature
    // value applies only from the next epoch
    sel_pending = 1'b1;
    q_sel   = 1'b1;
    start_i = 13'h1FFF;
    run_chips(LEN - 40 + 30, 1'b1);
    sel_pending = 1'b0;
    // R1, R8: reset straight into the quadrature code, steady enable
    start_q = 13'h0001;
    do_reset();
    run_chips(LEN + 20, 1'b0);
    // R2: a stretch with the enable held low
    repeat (20) drive_cycle(1'b0);
    run_chips(20, 1'b0);
    @(negedge clk);
    #2;
    // R7: the model must have seen every expected epoch
    n_checks++;
    if (epochs_seen != 4) begin
      n_fail++;
      $display("FAIL R7 epoch count: got %0d expected %0d", epochs_seen, 4);
    end
    finish_run();
  end
endmodule